// File: doc/BRIEF.md
# Watchdog Timer with Hung-Bus Recovery

This block is a software watchdog for a processor subsystem. Once enabled, a free-running counter climbs toward a terminal count. The terminal count comes from a two-bit period field and a prescale bit. Software keeps the watchdog quiet by writing a two-value key to a service port: first 0x55, which arms the service, and then 0xAA, which completes it. Any traffic may come between the two writes. That includes further writes to the service port.

When the counter reaches its terminal count, the block does one of two things:

- **Reset mode:** it emits a one-cycle internal reset request and sets a sticky cause flag. Only the power-on reset input clears that flag.
- **Interrupt mode:** it raises an interrupt request.

In interrupt mode the forced-acknowledge option handles a stuck handler. If the interrupt is still pending when a further full period runs out, the block drives a transfer-acknowledge onto the bus. This frees an access that no slave will ever terminate. The acknowledge is held until the bus controller reports the start of the next bus cycle. A status bit records that it happened, and the handler can poll that bit and then clear it.

A small byte-wide register port gives access to three registers: control, service and status. The enable bit, the period field and the prescale bit lock once the enable bit is set. The port has no stream data, so every pin is a plain level or strobe and there is no back-pressure.

Top module: `wdg_recovery`

## Requirements
- R1: After reset all of the following are low: `irq`, `force_ta` and `rst_req`. The control register (address 0) and the status register (address 2) both read 0.
- R2: In interrupt mode (control bit1 = 0, bit0 = 1 enables), `irq` rises exactly T cycles after the enabling write. It then stays high until a completed service.
- R3: T = 2^(BASE_LOG2 + STEP_LOG2*P), where P is control bits [4:3]. When control bit5 (prescale) is set, T is multiplied by 2^PRE_LOG2.
- R4: Writing 0x55 and then 0xAA to address 1 restarts the count, so the next timeout comes T cycles after the 0xAA write. Other writes between the two, including other values and repeated 0x55 writes to address 1, do not cancel the armed state.
- R5: Some writes to address 1 have no effect on the counter:
  - an 0xAA write that no armed 0x55 precedes;
  - a second 0xAA after a completed sequence;
  - any value other than 0x55 or 0xAA.
- R6: A completed key sequence drops a pending `irq` on the cycle of the 0xAA write.
- R7: Forced acknowledge is enabled by control bit2. With it set, a timeout that occurs while `irq` is pending asserts `force_ta` and sets status bit1. With bit2 clear, `force_ta` never asserts.
- R8: Once asserted, `force_ta` stays high until a cycle in which `bus_start` is high.
- R9: Writing 1 to status bit1 clears it. Writing 0 to it leaves it unchanged.
- R10: In reset mode (control bit1 = 1), a timeout produces a `rst_req` pulse exactly one cycle wide and sets status bit0. `irq` is not raised in this mode.
- R11: Status bit0 survives `rst_n` and is cleared only by `por_n`.
- R12: While the enable bit is set, writes to control do not change bits 0, [4:3] or 5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous system reset |
| por_n | input | 1 | Active-low power-on reset; also clears the reset-cause flag |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 control, 1 service, 2 status |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| bus_start | input | 1 | Start of a new bus cycle; releases the forced acknowledge |
| irq | output | 1 | Watchdog interrupt request |
| force_ta | output | 1 | Forced transfer-acknowledge to the bus |
| rst_req | output | 1 | One-cycle internal reset request |

## Verification
The assertions check the following on every cycle:
- the reset request is only ever one cycle wide;
- the forced acknowledge holds until a bus start, and rises only while an interrupt is already pending, together with its status flag;
- the interrupt falls only on a completed service;
- the cause flag stays set until power-on reset;
- the locked control fields never move while enabled.

Only the bench scenarios can show the absolute timing and the ordering rules. They check:
- that the timeout lands exactly at the selected terminal count for each period and for prescale;
- that stray, reordered or repeated service writes neither restart nor cancel the count;
- that write-one-to-clear works and that the cause flag survives a system reset.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  localparam int PER_W   = 2;
  localparam int PERIODS = 1 << PER_W;

  localparam logic [1:0] ADDR_CTL = 2'd0;
  localparam logic [1:0] ADDR_KEY = 2'd1;
  localparam logic [1:0] ADDR_STS = 2'd2;

  localparam logic [7:0] KEY_ARM  = 8'h55;
  localparam logic [7:0] KEY_FIRE = 8'hAA;

  localparam int STS_CAUSE = 0;
  localparam int STS_FAFLG = 1;

  // control register layout, MSB first: prescale, period, force-ack enable,
  // reset mode, enable
  typedef struct packed {
    logic             pre;
    logic [PER_W-1:0] per;
    logic             fa_en;
    logic             rst_mode;
    logic             en;
  } ctl_t;

  localparam int CTL_W = $bits(ctl_t);
endpackage

// File: rtl/wdg_regs.sv
module wdg_regs
  import wdg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic [1:0] addr,
  input  logic [7:0] wdata,
  input  logic       st_cause,
  input  logic       st_faflg,
  input  logic       st_irq,
  input  logic       st_fta,
  output ctl_t       ctl,
  output logic       key_wr,
  output logic [7:0] key_data,
  output logic       fa_clr,
  output logic [7:0] rdata
);
  ctl_t ctl_q;
  ctl_t wr_val;

  assign wr_val = ctl_t'(wdata[CTL_W-1:0]);

  // enable, period and prescale lock once enable is set; mode bits stay free
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
    end else if (wr && addr == ADDR_CTL) begin
      ctl_q.rst_mode <= wr_val.rst_mode;
      ctl_q.fa_en    <= wr_val.fa_en;
      if (!ctl_q.en) begin
        ctl_q.en  <= wr_val.en;
        ctl_q.per <= wr_val.per;
        ctl_q.pre <= wr_val.pre;
      end
    end
  end

  assign ctl      = ctl_q;
  assign key_wr   = wr && (addr == ADDR_KEY);
  assign key_data = wdata;
  assign fa_clr   = wr && (addr == ADDR_STS) && wdata[STS_FAFLG];

  always_comb begin
    rdata = '0;
    unique case (addr)
      ADDR_CTL: rdata[CTL_W-1:0] = ctl_q;
      ADDR_STS: rdata[3:0] = {st_fta, st_irq, st_faflg, st_cause};
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/wdg_key.sv
module wdg_key
  import wdg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       key_wr,
  input  logic [7:0] key_data,
  output logic       svc,
  output logic       armed
);
  logic armed_q;
  logic hit_arm;
  logic hit_fire;

  assign hit_arm  = key_wr && (key_data == KEY_ARM);
  assign hit_fire = key_wr && (key_data == KEY_FIRE);
  assign svc      = hit_fire && armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       armed_q <= 1'b0;
    else if (hit_arm) armed_q <= 1'b1;
    else if (svc)     armed_q <= 1'b0;
  end

  assign armed = armed_q;
endmodule

// File: rtl/wdg_timer.sv
module wdg_timer
  import wdg_pkg::*;
#(
  parameter int BASE_LOG2 = 9,
  parameter int STEP_LOG2 = 2,
  parameter int PRE_LOG2  = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [PER_W-1:0] per,
  input  logic             pre,
  input  logic             svc,
  output logic             tmo
);
  localparam int CW = BASE_LOG2 + STEP_LOG2 * (PERIODS - 1) + PRE_LOG2 + 1;

  logic [CW-1:0] lim_tab [2][PERIODS];
  logic [CW-1:0] lim;
  logic [CW-1:0] cnt_q;

  // terminal-count minus one for every period and prescale variant
  for (genvar s = 0; s < 2; s++) begin : g_pre
    for (genvar p = 0; p < PERIODS; p++) begin : g_per
      localparam int SH = BASE_LOG2 + STEP_LOG2 * p + (s == 1 ? PRE_LOG2 : 0);
      assign lim_tab[s][p] = (CW'(1) << SH) - CW'(1);
    end
  end

  assign lim = lim_tab[pre][per];
  assign tmo = en && !svc && (cnt_q >= lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (!en || svc || tmo) cnt_q <= '0;
    else                    cnt_q <= cnt_q + CW'(1);
  end
endmodule

// File: rtl/wdg_resp.sv
module wdg_resp (
  input  logic clk,
  input  logic rst_n,
  input  logic por_n,
  input  logic tmo,
  input  logic svc,
  input  logic rst_mode,
  input  logic fa_en,
  input  logic bus_start,
  input  logic fa_clr,
  output logic irq,
  output logic fta,
  output logic rst_req,
  output logic fa_flag,
  output logic cause
);
  logic irq_q, fta_q, req_q, flag_q, cause_q;
  logic tmo_irq, tmo_rst, fa_hit;

  assign tmo_irq = tmo && !rst_mode;
  assign tmo_rst = tmo && rst_mode;
  assign fa_hit  = tmo_irq && irq_q && fa_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q  <= 1'b0;
      fta_q  <= 1'b0;
      req_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      req_q <= tmo_rst;
      if (svc)          irq_q <= 1'b0;
      else if (tmo_irq) irq_q <= 1'b1;
      if (fa_hit)         fta_q <= 1'b1;
      else if (bus_start) fta_q <= 1'b0;
      if (fa_hit)      flag_q <= 1'b1;
      else if (fa_clr) flag_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)       cause_q <= 1'b0;
    else if (tmo_rst) cause_q <= 1'b1;
  end

  assign irq     = irq_q;
  assign fta     = fta_q;
  assign rst_req = req_q;
  assign fa_flag = flag_q;
  assign cause   = cause_q;
endmodule

// File: rtl/wdg_recovery.sv
module wdg_recovery
  import wdg_pkg::*;
#(
  parameter int BASE_LOG2 = 9,
  parameter int STEP_LOG2 = 2,
  parameter int PRE_LOG2  = 9
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       por_n,
  input  logic       reg_wr,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       bus_start,
  output logic       irq,
  output logic       force_ta,
  output logic       rst_req
);
  ctl_t       ctl_q;
  logic       key_wr;
  logic [7:0] key_data;
  logic       fa_clr;
  logic       svc;
  logic       armed;
  logic       tmo;
  logic       fa_flag;
  logic       cause;

  wdg_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (reg_wr),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .st_cause (cause),
    .st_faflg (fa_flag),
    .st_irq   (irq),
    .st_fta   (force_ta),
    .ctl      (ctl_q),
    .key_wr   (key_wr),
    .key_data (key_data),
    .fa_clr   (fa_clr),
    .rdata    (reg_rdata)
  );

  wdg_key u_key (
    .clk      (clk),
    .rst_n    (rst_n),
    .key_wr   (key_wr),
    .key_data (key_data),
    .svc      (svc),
    .armed    (armed)
  );

  wdg_timer #(
    .BASE_LOG2 (BASE_LOG2),
    .STEP_LOG2 (STEP_LOG2),
    .PRE_LOG2  (PRE_LOG2)
  ) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (ctl_q.en),
    .per   (ctl_q.per),
    .pre   (ctl_q.pre),
    .svc   (svc),
    .tmo   (tmo)
  );

  wdg_resp u_resp (
    .clk       (clk),
    .rst_n     (rst_n),
    .por_n     (por_n),
    .tmo       (tmo),
    .svc       (svc),
    .rst_mode  (ctl_q.rst_mode),
    .fa_en     (ctl_q.fa_en),
    .bus_start (bus_start),
    .fa_clr    (fa_clr),
    .irq       (irq),
    .fta       (force_ta),
    .rst_req   (rst_req),
    .fa_flag   (fa_flag),
    .cause     (cause)
  );
endmodule

// File: rtl/wdg_recovery_chk.sv
module wdg_recovery_chk
  import wdg_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             por_n,
  input logic             bus_start,
  input logic             irq,
  input logic             force_ta,
  input logic             rst_req,
  input logic             svc,
  input logic             fa_flag,
  input logic             cause,
  input logic [CTL_W-1:0] ctl
);
  ctl_t c;
  assign c = ctl_t'(ctl);

  AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req); // R10

  AST_FTA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    force_ta && !bus_start |=> force_ta); // R8

  AST_FTA_NEEDS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(force_ta) |-> $past(irq) && fa_flag); // R7

  AST_IRQ_FALL_ON_SVC: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(svc)); // R6

  AST_CAUSE_STICKY: assert property (@(posedge clk) disable iff (!por_n)
    cause |=> cause); // R11

  AST_CTL_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    c.en |=> c.en && $stable(c.per) && $stable(c.pre)); // R12
endmodule

bind wdg_recovery wdg_recovery_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .por_n     (por_n),
  .bus_start (bus_start),
  .irq       (irq),
  .force_ta  (force_ta),
  .rst_req   (rst_req),
  .svc       (svc),
  .fa_flag   (fa_flag),
  .cause     (cause),
  .ctl       (ctl_q)
);

// File: tb/wdg_recovery_tb.sv
`timescale 1ns/1ps
module wdg_recovery_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       por_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic       bus_start = 1'b0;
  logic       irq, force_ta, rst_req;

  int cyc = 0;
  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  typedef struct {
    int    at;
    int    sig;   // 0 irq, 1 force_ta, 2 rst_req
    logic  val;
    string tag;
  } exp_t;
  exp_t q[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  wdg_recovery #(.BASE_LOG2(3), .STEP_LOG2(2), .PRE_LOG2(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .por_n(por_n), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .bus_start(bus_start), .irq(irq), .force_ta(force_ta), .rst_req(rst_req)
  );

  function automatic logic pick(int s);
    case (s)
      0: pick = irq;
      1: pick = force_ta;
      default: pick = rst_req;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // monitor: pops expectations as their cycle arrives
  initial begin
    forever begin
      @(negedge clk);
      while (q.size() > 0 && q[0].at <= cyc) begin
        exp_t e;
        e = q.pop_front();
        if (e.at < cyc) chk({e.tag, " late"}, 8'd0, 8'd1);
        else chk(e.tag, {7'd0, pick(e.sig)}, {7'd0, e.val});
      end
    end
  end

  task automatic expect_at(input int at, input int s, input logic v, input string tag);
    exp_t e;
    e.at = at; e.sig = s; e.val = v; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d, output int e);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    e = cyc;
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [7:0] mask,
                    input logic [7:0] exp, input string tag);
    @(negedge clk);
    reg_addr = a;
    #1;
    chk(tag, reg_rdata & mask, exp);
  endtask

  task automatic drain();
    while (q.size() > 0) @(negedge clk);
  endtask

  task automatic sys_reset(input bit with_por);
    @(negedge clk);
    rst_n = 1'b0;
    if (with_por) por_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    por_n = 1'b1;
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_up();
  end

  initial begin
    int e, s, t, d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1; por_n = 1'b1;

    // R1 reset state
    @(negedge clk);
    chk("R1 irq", {7'd0, irq}, 8'd0);
    chk("R1 force_ta", {7'd0, force_ta}, 8'd0);
    chk("R1 rst_req", {7'd0, rst_req}, 8'd0);
    rd(2'd0, 8'hFF, 8'h00, "R1 ctl");
    rd(2'd2, 8'hFF, 8'h00, "R1 sts");

    // R2 interrupt timeout, period 0 -> 8 cycles; R7 no force-ack when disabled
    wr(2'd0, 8'h01, e);
    expect_at(e + 7, 0, 1'b0, "R2 before tmo");
    expect_at(e + 8, 0, 1'b1, "R2 at tmo");
    expect_at(e + 17, 0, 1'b1, "R2 held");
    expect_at(e + 17, 1, 1'b0, "R7 disabled");
    drain();

    // R3 period 2 -> 128
    sys_reset(0);
    wr(2'd0, 8'h11, e);
    expect_at(e + 127, 0, 1'b0, "R3 per2 before");
    expect_at(e + 128, 0, 1'b1, "R3 per2 at");
    drain();
    // R3 prescale, period 0 -> 32
    sys_reset(0);
    wr(2'd0, 8'h21, e);
    expect_at(e + 8, 0, 1'b0, "R3 pre not base");
    expect_at(e + 31, 0, 1'b0, "R3 pre before");
    expect_at(e + 32, 0, 1'b1, "R3 pre at");
    drain();

    // R4 key with intervening traffic, period 1 -> 32
    sys_reset(0);
    wr(2'd0, 8'h09, e);
    wr(2'd1, 8'h55, d);
    wr(2'd1, 8'h33, d);
    wr(2'd1, 8'h55, d);
    wr(2'd2, 8'h00, d);
    wr(2'd1, 8'hAA, s);
    expect_at(e + 32, 0, 1'b0, "R4 reloaded");
    // R5 stray writes must not reload
    wr(2'd1, 8'hAA, d);
    wr(2'd1, 8'h77, d);
    expect_at(s + 31, 0, 1'b0, "R4 before new tmo");
    expect_at(s + 32, 0, 1'b1, "R5 stray ignored");
    drain();

    // R6 service clears pending irq
    chk("R6 pending", {7'd0, irq}, 8'd1);
    wr(2'd1, 8'h55, d);
    wr(2'd1, 8'hAA, t);
    chk("R6 cleared", {7'd0, irq}, 8'd0);
    expect_at(t + 32, 0, 1'b1, "R6 restart");
    drain();

    // R5 lone AA after reset does not service
    sys_reset(0);
    wr(2'd0, 8'h09, e);
    wr(2'd1, 8'hAA, d);
    expect_at(e + 32, 0, 1'b1, "R5 lone AA");
    drain();

    // R7 forced acknowledge, period 1
    sys_reset(0);
    wr(2'd0, 8'h0D, e);
    expect_at(e + 32, 0, 1'b1, "R7 irq");
    expect_at(e + 63, 1, 1'b0, "R7 before fta");
    expect_at(e + 64, 1, 1'b1, "R7 fta");
    drain();
    rd(2'd2, 8'h02, 8'h02, "R7 flag");
    repeat (5) @(negedge clk);
    chk("R8 held", {7'd0, force_ta}, 8'd1);
    bus_start = 1'b1;
    @(negedge clk);
    bus_start = 1'b0;
    chk("R8 released", {7'd0, force_ta}, 8'd0);
    wr(2'd2, 8'h00, d);
    rd(2'd2, 8'h02, 8'h02, "R9 write0 keeps");
    wr(2'd2, 8'h02, d);
    rd(2'd2, 8'h02, 8'h00, "R9 w1c");

    // R10 reset mode
    sys_reset(0);
    wr(2'd0, 8'h03, e);
    expect_at(e + 7, 2, 1'b0, "R10 before");
    expect_at(e + 8, 2, 1'b1, "R10 pulse");
    expect_at(e + 9, 2, 1'b0, "R10 one cycle");
    expect_at(e + 9, 0, 1'b0, "R10 no irq");
    drain();
    rd(2'd2, 8'h01, 8'h01, "R10 cause");
    sys_reset(0);
    rd(2'd2, 8'h01, 8'h01, "R11 survives rst_n");
    sys_reset(1);
    rd(2'd2, 8'h01, 8'h00, "R11 por clears");

    // R12 lock
    wr(2'd0, 8'h01, e);
    wr(2'd0, 8'h38, d);
    rd(2'd0, 8'h39, 8'h01, "R12 locked");
    expect_at(e + 8, 0, 1'b1, "R12 period kept");
    drain();

    finish_up();
  end
endmodule